// File: doc/BRIEF.md
# Dual Programmable Clock-Enable Divider

This block takes one fast reference clock and produces two slower rates: a system rate and a core rate. Each rate is a single-cycle enable pulse on the reference clock, not a gated clock. The system rate divides the reference by any integer from 1 to 15. The core rate divides it by 1, 2, 4 or 8, selected by a two-bit code.

Software sets both ratios through one small setting word, written on a single-cycle write strobe. Each ratio can be changed while the block runs, with no pause and no relock. A new ratio is held as pending and only moves into effect when the channel's current period ends, so no period is ever cut short.

A readback port shows the settings that are actually in force, which can differ from the last value written. Keeping the system rate under its frequency ceiling is the job of the software that picks the ratio.

Top module: `clkdiv_pair`

## Requirements
- R1: The setting word has bits [5:2] as the system ratio N (unsigned) and bits [1:0] as the core code. `wr_en` is sampled on the rising edge of `clk_ref`.
- R2: With system ratio N, `sys_en` is high for exactly one reference cycle in every N cycles. The spacing between rising samples of `sys_en` is N.
- R3: Core code 0 divides by 1, code 1 by 2, code 2 by 4 and code 3 by 8. `core_en` is high one cycle per period.
- R4: A write whose system field is 0 leaves the system ratio unchanged. The core field of that same write is still accepted.
- R5: A written ratio takes effect only at the end of the channel's current period, so no period is shortened. A write sampled on the same edge that ends a period takes effect one period later.
- R6: After reset the system ratio is 5, the core code is 0, and `rd_data` reads 0x14.
- R7: `rd_data` uses the R1 layout and returns the settings in effect, not the pending ones.
- R8: A ratio of 1 (system N=1 or core code 0) holds its enable high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the setting word |
| wr_data | input | 6 | Setting word: [5:2] system ratio, [1:0] core code |
| rd_data | output | 6 | Settings in effect, same layout |
| sys_en | output | 1 | System-rate enable pulse |
| core_en | output | 1 | Core-rate enable pulse |

## Verification
Every write is issued in a cycle where the target enable is high, so it is sampled on the edge that ends a period. One more period at the old ratio is therefore due before the new spacing appears, and `rd_data` changes on that later boundary edge. The driver queues the expected pulse spacings at exactly that point. A monitor measures the spacing between pulses on the falling edge and compares each one against the queue. Readback is sampled one falling edge after the write, to confirm it still holds the old value, and again once the queues have drained, to confirm the new one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SYS_FIELD_W  = 4;
  localparam int CORE_FIELD_W = 2;
  localparam int WORD_W       = SYS_FIELD_W + CORE_FIELD_W;

  // largest core ratio is 2**(2**CORE_FIELD_W - 1)
  localparam int CORE_MAX_SHIFT = (1 << CORE_FIELD_W) - 1;
  localparam int CORE_CNT_W     = CORE_MAX_SHIFT + 1;
  localparam int CNT_W = (SYS_FIELD_W > CORE_CNT_W) ? SYS_FIELD_W : CORE_CNT_W;

  typedef struct packed {
    logic [SYS_FIELD_W-1:0]  sys_n;
    logic [CORE_FIELD_W-1:0] core_code;
  } div_word_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_setting_reg.sv
module clkdiv_setting_reg #(
  parameter int SYS_W     = 4,
  parameter int CORE_W    = 2,
  parameter int SYS_INIT  = 5,
  parameter int CORE_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SYS_W-1:0]  wr_sys,
  input  logic [CORE_W-1:0] wr_core,
  output logic [SYS_W-1:0]  pend_sys,
  output logic [CORE_W-1:0] pend_core
);
  logic [SYS_W-1:0]  sys_d;
  logic [CORE_W-1:0] core_d;
  logic              sys_legal;

  assign sys_legal = (wr_sys != '0);

  always_comb begin
    sys_d  = pend_sys;
    core_d = pend_core;
    if (wr_en) begin
      core_d = wr_core;
      if (sys_legal) sys_d = wr_sys;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sys  <= SYS_W'(SYS_INIT);
      pend_core <= CORE_W'(CORE_INIT);
    end else begin
      pend_sys  <= sys_d;
      pend_core <= core_d;
    end
  end
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int SET_W    = 4,
  parameter int CNT_W    = 4,
  parameter int SET_INIT = 1,
  parameter bit POW2     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] pend_set,
  output logic [SET_W-1:0] act_set,
  output logic             tick
);
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [SET_W-1:0] set_d;
  logic             period_end;

  generate
    if (POW2) begin : g_pow2
      assign ratio = CNT_W'(1) << act_set;
    end else begin : g_linear
      assign ratio = CNT_W'(act_set);
    end
  endgenerate

  assign period_end = (cnt_q == (ratio - CNT_W'(1)));

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    set_d = act_set;
    if (period_end) begin
      cnt_d = '0;
      set_d = pend_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_set <= SET_W'(SET_INIT);
    end else begin
      cnt_q   <= cnt_d;
      act_set <= set_d;
    end
  end

  assign tick = period_end;
endmodule

// File: rtl/clkdiv_pair.sv
module clkdiv_pair
  import clkdiv_pkg::*;
#(
  parameter int SYS_INIT  = 5,
  parameter int CORE_INIT = 0
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              sys_en,
  output logic              core_en
);
  logic                    rst_sync_n;
  div_word_t               wr_word;
  div_word_t               act_word;
  logic [SYS_FIELD_W-1:0]  pend_sys;
  logic [CORE_FIELD_W-1:0] pend_core;

  assign wr_word = div_word_t'(wr_data);

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_ref),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  clkdiv_setting_reg #(
    .SYS_W     (SYS_FIELD_W),
    .CORE_W    (CORE_FIELD_W),
    .SYS_INIT  (SYS_INIT),
    .CORE_INIT (CORE_INIT)
  ) u_setting (
    .clk       (clk_ref),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_sys    (wr_word.sys_n),
    .wr_core   (wr_word.core_code),
    .pend_sys  (pend_sys),
    .pend_core (pend_core)
  );

  clkdiv_channel #(
    .SET_W    (SYS_FIELD_W),
    .CNT_W    (CNT_W),
    .SET_INIT (SYS_INIT),
    .POW2     (1'b0)
  ) u_sys_div (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .pend_set (pend_sys),
    .act_set  (act_word.sys_n),
    .tick     (sys_en)
  );

  clkdiv_channel #(
    .SET_W    (CORE_FIELD_W),
    .CNT_W    (CNT_W),
    .SET_INIT (CORE_INIT),
    .POW2     (1'b1)
  ) u_core_div (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .pend_set (pend_core),
    .act_set  (act_word.core_code),
    .tick     (core_en)
  );

  assign rd_data = act_word;
endmodule

// File: rtl/clkdiv_pair_chk.sv
module clkdiv_pair_chk #(
  parameter int SYS_W  = 4,
  parameter int CORE_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sys_en,
  input logic                    core_en,
  input logic [SYS_W+CORE_W-1:0] rd_data
);
  localparam int SYS_MAX = (1 << SYS_W) - 1;
  localparam int GAP_W   = SYS_W + 1;

  logic [SYS_W-1:0]  rd_sys;
  logic [CORE_W-1:0] rd_core;
  logic [GAP_W-1:0]  gap_q;

  assign rd_sys  = rd_data[SYS_W+CORE_W-1:CORE_W];
  assign rd_core = rd_data[CORE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= '0;
    else if (sys_en)                   gap_q <= '0;
    else if (gap_q != GAP_W'(SYS_MAX)) gap_q <= gap_q + GAP_W'(1);
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en |=> (!sys_en || rd_sys == SYS_W'(1)));

  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < GAP_W'(SYS_MAX));

  assert_core_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> (!core_en || rd_core == '0));

  assert_no_zero_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sys != '0);

  assert_sys_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sys != $past(rd_sys)) |-> $past(sys_en));

  assert_core_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_core != $past(rd_core)) |-> $past(core_en));

  assert_div1_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_core == '0) |-> core_en);
endmodule

bind clkdiv_pair clkdiv_pair_chk #(
  .SYS_W  (clkdiv_pkg::SYS_FIELD_W),
  .CORE_W (clkdiv_pkg::CORE_FIELD_W)
) u_chk (
  .clk     (clk_ref),
  .rst_n   (rst_sync_n),
  .sys_en  (sys_en),
  .core_en (core_en),
  .rd_data (rd_data)
);

// File: tb/clkdiv_pair_test.sv
module clkdiv_pair_test;
  logic       clk_ref;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_data;
  logic [5:0] rd_data;
  logic       sys_en;
  logic       core_en;

  int n_chk;
  int n_err;
  int cyc;
  int last_sys;
  int last_core;
  bit done;
  int q_sys[$];
  int q_core[$];

  clkdiv_pair uut (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .sys_en  (sys_en),
    .core_en (core_en)
  );

  initial clk_ref = 1'b0;
  always #10 clk_ref = ~clk_ref;

  initial cyc = 0;
  always @(posedge clk_ref) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare pulse spacing against queued expectations
  always @(negedge clk_ref) begin
    if (rst_n && !done) begin
      if (sys_en) begin
        if (last_sys >= 0 && q_sys.size() > 0) begin
          int e;
          e = q_sys.pop_front();
          check("R2/R5 sys spacing", cyc - last_sys, e);
        end
        last_sys = cyc;
      end
      if (core_en) begin
        if (last_core >= 0 && q_core.size() > 0) begin
          int e;
          e = q_core.pop_front();
          check("R3/R5/R8 core spacing", cyc - last_core, e);
        end
        last_core = cyc;
      end
    end
  end

  task automatic sync_pulse(bit on_sys);
    do @(negedge clk_ref); while (on_sys ? !sys_en : !core_en);
    #1;
  endtask

  task automatic start_wr(logic [3:0] s, logic [1:0] c);
    wr_en   = 1'b1;
    wr_data = {s, c};
  endtask

  task automatic end_wr();
    @(negedge clk_ref);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q_sys.size() > 0 || q_core.size() > 0) @(negedge clk_ref);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk_ref);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    last_sys = -1; last_core = -1;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);
    #1;
    check("R6 reset readback", int'(rd_data), 'h14);
    check("R6/R8 core div1 high", int'(core_en), 1);

    // R2: default ratio 5
    q_sys.push_back(5); q_sys.push_back(5); q_sys.push_back(5);
    drain();

    // R5/R7: retune system to 3
    sync_pulse(1'b1);
    start_wr(4'd3, 2'd0);
    q_sys.push_back(5); q_sys.push_back(3); q_sys.push_back(3); q_sys.push_back(3);
    end_wr();
    check("R7 readback still old", int'(rd_data[5:2]), 5);
    drain();
    check("R7 readback new sys", int'(rd_data[5:2]), 3);

    // R2 maximum ratio
    sync_pulse(1'b1);
    start_wr(4'd15, 2'd0);
    q_sys.push_back(3); q_sys.push_back(15); q_sys.push_back(15);
    end_wr();
    drain();

    // R8 sys ratio 1
    sync_pulse(1'b1);
    start_wr(4'd1, 2'd0);
    q_sys.push_back(15); q_sys.push_back(1); q_sys.push_back(1); q_sys.push_back(1);
    end_wr();
    drain();
    check("R8 sys div1 high", int'(sys_en), 1);

    sync_pulse(1'b1);
    start_wr(4'd7, 2'd0);
    q_sys.push_back(1); q_sys.push_back(7); q_sys.push_back(7);
    end_wr();
    drain();

    // R4: zero system field ignored, core field taken (core ratio 1 now)
    sync_pulse(1'b1);
    start_wr(4'd0, 2'd1);
    q_sys.push_back(7); q_sys.push_back(7); q_sys.push_back(7);
    q_core.push_back(1); q_core.push_back(2); q_core.push_back(2); q_core.push_back(2);
    end_wr();
    drain();
    check("R4 sys kept", int'(rd_data[5:2]), 7);
    check("R4 core taken", int'(rd_data[1:0]), 1);

    // R3 core codes
    sync_pulse(1'b0);
    start_wr(4'd7, 2'd3);
    q_core.push_back(2); q_core.push_back(8); q_core.push_back(8);
    end_wr();
    check("R7 core readback old", int'(rd_data[1:0]), 1);
    drain();

    sync_pulse(1'b0);
    start_wr(4'd7, 2'd2);
    q_core.push_back(8); q_core.push_back(4); q_core.push_back(4);
    end_wr();
    drain();

    sync_pulse(1'b0);
    start_wr(4'd7, 2'd0);
    q_core.push_back(4); q_core.push_back(1); q_core.push_back(1); q_core.push_back(1);
    end_wr();
    drain();
    check("R1/R7 final readback", int'(rd_data), 28);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule